// File: doc/BRIEF.md
# Power-Domain Control Signal Generator

This block produces one sleep control level per power domain of a reconfigurable fabric. Each power-gating region raises a sleep request. The request comes either from the region's own idle counter or from a host input, and a configuration bit picks the source. A per-region bitmap names the domains that cover the region. A domain sleeps only when every region mapped onto it asks to sleep.

The block also derives a gating level for each logic block and each routing-switch path from the domain controls. A logic block can be tied permanently asleep when unused (static gating), or it can follow its domain (dynamic gating). A switch path can be forced to active, so that routing passing through a sleeping domain keeps working. All settings are written through a plain address, data and write-enable port.

A control level of 1 means sleep and 0 means active. The level is meant to drive the lower supply rail of the gated logic.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: There is exactly one control output per domain (`dom_sleep_o[d]`), where 1 means sleep and 0 means active.
- R2: A domain's control is the AND of the requests of all regions whose map has bit d set. A domain that no region maps to reads 1.
- R3: A region whose map has several bits set drives its request onto every one of those domains.
- R4: Block b belongs to domain b mod N_DOMAINS. When its static bit is 1, `blk_sleep_o[b]` is 1 whatever the domains do. When the bit is 0, the output equals its domain's control.
- R5: Switch path s belongs to domain s mod N_DOMAINS. When its override bit is 1, `sw_sleep_o[s]` is 0. When the bit is 0, the output equals its domain's control.
- R6: Take a timer-sourced region with threshold T and its wake input low. Its request rises once T rising clock edges have passed since wake was last sampled high, and it then stays high. The counter is CNT_W bits wide, 36 by default, which covers about 4e10 cycles.
- R7: A high wake input drops the timer-sourced request to 0 in the same cycle and restarts the count from zero.
- R8: When a region's source bit is 1, its request equals `host_sleep_i[r]`, and its wake input and timer have no effect on it.
- R9: Write address map, with writes taking effect at the clock edge where `cfg_we_i` is high:
  - addresses 0..R-1 hold the region map (data bits D-1:0);
  - addresses R..2R-1 hold the region threshold (all CNT_W bits);
  - address 2R holds the static bits;
  - address 2R+1 holds the override bits;
  - address 2R+2 holds the source bits.
  Writes to any other address change nothing.
- R10: After reset:
  - every map is all ones;
  - every threshold is all ones;
  - the static, override and source bits are 0;
  - the counters are 0.
  So all domains, blocks and switches read 0 (active).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | N_REGIONS | Activity per region; clears its idle count |
| host_sleep_i | input | N_REGIONS | Host sleep request per region |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | ADDR_W | Configuration write address |
| cfg_wdata_i | input | CNT_W | Configuration write data |
| dom_sleep_o | output | N_DOMAINS | Control level per domain (1 = sleep) |
| blk_sleep_o | output | N_BLOCKS | Gating level per logic block |
| sw_sleep_o | output | N_SWITCHES | Gating level per routing-switch path |

## Verification
The combining function is driven with host requests under three layouts:
- every region covering every domain, which shows that one awake region keeps all domains awake;
- a single region spanning two domains, which shows that a value fans out to several domains;
- all regions folded onto one domain, which shows that empty domains sleep.

The idle timer is driven with a short threshold and checked one edge before and at the expected edge. It is then interrupted by wake mid-sleep and re-counted, which separates an off-by-one count from a missing restart. Static and override bits are set in patterns that differ per index, and unmapped writes are sent, so that per-index placement and write decoding are both exposed.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    // 36 bits cover roughly 6.9e10 cycles, above the 4e10 needed
    localparam int CNT_W_DEF = 36;

    function automatic int owner_of(int idx, int n_dom);
        return idx % n_dom;
    endfunction
endpackage

// File: rtl/pdc_idle_timer.sv
module pdc_idle_timer #(
    parameter int CNT_W = pdc_pkg::CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wake_i,
    input  logic             host_sel_i,
    input  logic             host_sleep_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wake_i) begin
            s_d.cnt = '0;
        end else if (s_q.cnt < thr_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (host_sel_i) begin
            req_o = host_sleep_i;
        end else begin
            req_o = !wake_i && (s_q.cnt >= thr_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: wake restarts the count
    p_wake_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |=> (s_q.cnt == '0));

    // R6: below threshold the count advances by one per idle cycle
    p_count_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wake_i && (s_q.cnt < thr_i)) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));

    // R6: once asleep the count holds (saturation)
    p_sleep_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !host_sel_i && !wake_i) |=> (s_q.cnt == $past(s_q.cnt)));
endmodule

// File: rtl/pdc_domain_and.sv
module pdc_domain_and #(
    parameter int N_REGIONS = 4,
    parameter int N_DOMAINS = 4
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic [N_REGIONS-1:0]                req_i,
    input  logic [N_REGIONS-1:0][N_DOMAINS-1:0] map_i,
    output logic [N_DOMAINS-1:0]                dom_sleep_o
);
    for (genvar d = 0; d < N_DOMAINS; d++) begin : g_dom
        logic [N_REGIONS-1:0] col;
        for (genvar r = 0; r < N_REGIONS; r++) begin : g_col
            assign col[r] = map_i[r][d];
        end
        // unmapped regions do not hold the domain awake
        assign dom_sleep_o[d] = &(req_i | ~col);

        // R2: a domain with no region mapped to it sleeps
        p_empty_sleeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (col == '0) |-> dom_sleep_o[d]);
    end

    // R2: all regions asleep means every domain asleep
    p_all_sleep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&req_i) |-> (&dom_sleep_o));
endmodule

// File: rtl/pdc_gate_apply.sv
module pdc_gate_apply #(
    parameter int N_DOMAINS  = 4,
    parameter int N_BLOCKS   = 8,
    parameter int N_SWITCHES = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N_DOMAINS-1:0]  dom_i,
    input  logic [N_BLOCKS-1:0]   stat_i,
    input  logic [N_SWITCHES-1:0] ovr_i,
    output logic [N_BLOCKS-1:0]   blk_sleep_o,
    output logic [N_SWITCHES-1:0] sw_sleep_o
);
    for (genvar b = 0; b < N_BLOCKS; b++) begin : g_blk
        localparam int OWN = pdc_pkg::owner_of(b, N_DOMAINS);
        assign blk_sleep_o[b] = stat_i[b] | dom_i[OWN];

        // R4: a statically gated block never wakes
        p_static_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            stat_i[b] |-> blk_sleep_o[b]);
    end

    for (genvar s = 0; s < N_SWITCHES; s++) begin : g_sw
        localparam int OWN = pdc_pkg::owner_of(s, N_DOMAINS);
        assign sw_sleep_o[s] = !ovr_i[s] && dom_i[OWN];

        // R5: an overridden path is always active
        p_override_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ovr_i[s] |-> !sw_sleep_o[s]);
    end
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl #(
    parameter  int N_REGIONS  = 4,
    parameter  int N_DOMAINS  = 4,
    parameter  int N_BLOCKS   = 8,
    parameter  int N_SWITCHES = 4,
    parameter  int CNT_W      = pdc_pkg::CNT_W_DEF,
    localparam int ADDR_W     = $clog2(2 * N_REGIONS + 3)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N_REGIONS-1:0]  wake_i,
    input  logic [N_REGIONS-1:0]  host_sleep_i,
    input  logic                  cfg_we_i,
    input  logic [ADDR_W-1:0]     cfg_addr_i,
    input  logic [CNT_W-1:0]      cfg_wdata_i,
    output logic [N_DOMAINS-1:0]  dom_sleep_o,
    output logic [N_BLOCKS-1:0]   blk_sleep_o,
    output logic [N_SWITCHES-1:0] sw_sleep_o
);
    localparam int A_THR  = N_REGIONS;
    localparam int A_STAT = 2 * N_REGIONS;
    localparam int A_OVR  = A_STAT + 1;
    localparam int A_SRC  = A_STAT + 2;

    typedef struct packed {
        logic [N_REGIONS-1:0][N_DOMAINS-1:0] map;
        logic [N_REGIONS-1:0][CNT_W-1:0]     thr;
        logic [N_BLOCKS-1:0]                 stat;
        logic [N_SWITCHES-1:0]               ovr;
        logic [N_REGIONS-1:0]                src;
    } cfg_t;

    cfg_t c_d, c_q;
    logic [N_REGIONS-1:0] req;

    always_comb begin
        int a;
        a   = int'(cfg_addr_i);
        c_d = c_q;
        if (cfg_we_i) begin
            for (int r = 0; r < N_REGIONS; r++) begin
                if (a == r)         c_d.map[r] = cfg_wdata_i[N_DOMAINS-1:0];
                if (a == A_THR + r) c_d.thr[r] = cfg_wdata_i;
            end
            if (a == A_STAT) c_d.stat = cfg_wdata_i[N_BLOCKS-1:0];
            if (a == A_OVR)  c_d.ovr  = cfg_wdata_i[N_SWITCHES-1:0];
            if (a == A_SRC)  c_d.src  = cfg_wdata_i[N_REGIONS-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q      <= '0;
            c_q.map  <= '1;
            c_q.thr  <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    for (genvar r = 0; r < N_REGIONS; r++) begin : g_tmr
        pdc_idle_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .wake_i       (wake_i[r]),
            .host_sel_i   (c_q.src[r]),
            .host_sleep_i (host_sleep_i[r]),
            .thr_i        (c_q.thr[r]),
            .req_o        (req[r])
        );
    end

    pdc_domain_and #(.N_REGIONS(N_REGIONS), .N_DOMAINS(N_DOMAINS)) u_and (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (req),
        .map_i       (c_q.map),
        .dom_sleep_o (dom_sleep_o)
    );

    pdc_gate_apply #(.N_DOMAINS(N_DOMAINS), .N_BLOCKS(N_BLOCKS),
                     .N_SWITCHES(N_SWITCHES)) u_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .dom_i       (dom_sleep_o),
        .stat_i      (c_q.stat),
        .ovr_i       (c_q.ovr),
        .blk_sleep_o (blk_sleep_o),
        .sw_sleep_o  (sw_sleep_o)
    );

    // R9: writes outside the map leave the configuration untouched
    p_cfg_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && (int'(cfg_addr_i) > A_SRC)) |=> (c_q == $past(c_q)));

    // R9: a static-bit write lands on the next edge
    p_cfg_stat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && (int'(cfg_addr_i) == A_STAT))
        |=> (c_q.stat == $past(cfg_wdata_i[N_BLOCKS-1:0])));
endmodule

// File: tb/pwr_domain_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_domain_ctrl_tb_top;
    localparam int R = 4, D = 4, B = 8, S = 4, CW = 36;
    localparam int AW = $clog2(2 * R + 3);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [R-1:0]  wake, host;
    logic          we;
    logic [AW-1:0] addr;
    logic [CW-1:0] wdata;
    logic [D-1:0]  dom;
    logic [B-1:0]  blk;
    logic [S-1:0]  sw;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pwr_domain_ctrl #(.N_REGIONS(R), .N_DOMAINS(D), .N_BLOCKS(B),
                      .N_SWITCHES(S), .CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .host_sleep_i(host),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .dom_sleep_o(dom), .blk_sleep_o(blk), .sw_sleep_o(sw));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        wake = '1; host = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [CW-1:0] d);
        we = 1'b1; addr = AW'(a); wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 dom", 64'(dom), 64'h0);
        chk("R10 blk", 64'(blk), 64'h0);
        chk("R10 sw", 64'(sw), 64'h0);
        wake = '0;
        repeat (10) @(negedge clk);
        chk("R10 R1 long threshold keeps domains active", 64'(dom), 64'h0);
    endtask

    task automatic t_timer();
        do_reset();
        for (int r = 0; r < R; r++) wr(r, CW'(1 << r));
        wr(R + 0, CW'(5));
        wake[0] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R6 one edge early", 64'(dom), 64'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R6 R1 sleep at threshold", 64'(dom), 64'h1);
        chk("R4 blocks follow domain0", 64'(blk), 64'h11);
        chk("R5 switch follows domain0", 64'(sw), 64'h1);
        repeat (20) @(negedge clk);
        chk("R6 stays asleep", 64'(dom), 64'h1);
        wake[0] = 1'b1;
        #1;
        chk("R7 wake same cycle", 64'(dom), 64'h0);
        @(negedge clk);
        wake[0] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R7 count restarted", 64'(dom), 64'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 R6 sleeps again", 64'(dom), 64'h1);
    endtask

    task automatic t_combine();
        do_reset();
        wr(2 * R + 2, CW'(4'hF));
        host = 4'b0111;
        #1;
        chk("R2 one awake region keeps all awake", 64'(dom), 64'h0);
        host = 4'b1111;
        #1;
        chk("R2 all asleep", 64'(dom), 64'hF);
        wr(0, CW'(4'b0011));
        for (int r = 1; r < R; r++) wr(r, CW'(4'b1100));
        host = 4'b0001;
        #1;
        chk("R3 region0 drives domains 0 and 1", 64'(dom), 64'h3);
        for (int r = 0; r < R; r++) wr(r, CW'(4'b0001));
        host = 4'b0000;
        #1;
        chk("R2 empty domains sleep", 64'(dom), 64'hE);
    endtask

    task automatic t_host_src();
        do_reset();
        for (int r = 0; r < R; r++) wr(r, CW'(1 << r));
        wr(R + 1, CW'(0));
        wr(2 * R + 2, CW'(4'b0010));
        host = 4'b0001;
        wake = 4'b0000;
        #1;
        chk("R8 host low keeps region1 awake despite zero threshold", 64'(dom[1]), 64'h0);
        host = 4'b0010;
        wake = 4'b0010;
        #1;
        chk("R8 host high sleeps region1 despite wake", 64'(dom), 64'h2);
    endtask

    task automatic t_gating();
        do_reset();
        wr(2 * R, CW'(8'h0F));
        chk("R4 static blocks asleep, others active", 64'(blk), 64'h0F);
        wr(2 * R + 2, CW'(4'hF));
        host = 4'hF;
        #1;
        chk("R5 switches follow sleeping domains", 64'(sw), 64'hF);
        wr(2 * R + 1, CW'(4'b0101));
        chk("R5 overridden switches active", 64'(sw), 64'hA);
        wr(2 * R, CW'(8'h00));
        chk("R4 dynamic blocks follow domains", 64'(blk), 64'hFF);
        host = 4'h0;
        wr(12, '1);
        wr(15, '1);
        chk("R9 unmapped write ignored blk", 64'(blk), 64'h00);
        chk("R9 unmapped write ignored sw", 64'(sw), 64'h0);
        chk("R9 unmapped write ignored dom", 64'(dom), 64'h0);
    endtask

    initial begin
        t_reset();
        t_timer();
        t_combine();
        t_host_src();
        t_gating();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule